// File: doc/BRIEF.md
# Byte-Accessed Reloadable Up/Down Timer

This block is a 16-bit interval timer that a processor reaches over a narrow 8-bit register bus. The bus carries a 3-bit register offset, a write strobe, a read strobe, write data and registered read data. A prescaler divides the system clock into ticks. On each tick a 16-bit accumulator moves one step toward zero, upward through the 0xFFFF wrap or downward. When the step lands on zero the block raises a one-cycle event. It then either reloads a programmed value and keeps running (periodic mode) or parks at zero and drops its own run bit (one-shot mode).

Every 16-bit quantity is split into a low and a high byte on the bus. A low-byte write only fills a holding byte. The high-byte write commits the full word in one cycle. Reading the low byte of the count freezes the whole count in a snapshot, so the following high-byte read matches it even though the timer keeps running.

Offsets: 0 MODE, 1 prescaler low, 2 prescaler high, 3 reload low, 4 reload high, 5 count low, 6 count high, 7 unused.

Top module: `tick_timer_top`

## Requirements
- R1: After synchronous reset, every readable register reads 0 and `zero_evt` is low. The timer is stopped, counting up, in one-shot mode.
- R2: The MODE register (offset 0) has RUN at bit 0, REPEAT at bit 1, DOWN at bit 2 and RESTART at bit 3. A read returns RUN, REPEAT and DOWN. RESTART and bits 7..4 always read 0, and writes to bits 7..4 have no effect.
- R3: While RUN is set, a tick occurs every (divisor + 1) clock cycles, so a divisor of 0 ticks every cycle. While RUN is clear the prescaler count is held at 0. Committing a new divisor (offset 2 write) restarts the count at 0.
- R4: With DOWN = 0, each tick adds 1 to the count. The step from 0xFFFF to 0x0000 is a zero crossing.
- R5: With DOWN = 1, each tick subtracts 1 from the count. A step that lands on 0 is a zero crossing.
- R6: On a zero crossing, `zero_evt` is high for the one cycle after the tick. With REPEAT set, the reload value is stored instead of zero and RUN stays set.
- R7: On a zero crossing with REPEAT clear, the count is stored as 0 and RUN is cleared by hardware in the same cycle.
- R8: A MODE write with RESTART = 1 loads the reload value into the count at once. A count-high commit loads the new word at once. Either load takes precedence over a tick in the same cycle, and that tick is dropped.
- R9: Writes to offsets 1, 3 and 5 only store a holding byte. A write to offsets 2, 4 or 6 commits {written byte, held byte}. A high-byte write with no fresh low write reuses the stale held byte.
- R10: A read of offset 5 returns the live low byte and captures the full count in a snapshot. A read of offset 6 returns the snapshot's high byte, not the live high byte.
- R11: `rd_data` is registered and valid in the cycle after the read strobe. Offsets 1 to 4 and 7 read 0. `rd_data` is 0 in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_off | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data |
| zero_evt | output | 1 | One-cycle pulse after a zero crossing |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high together and that each access lasts one cycle. This guarantees that at most one register is written per cycle, so no high commit coincides with its own low latch. The bench issues every access through tasks that raise a single strobe for exactly one cycle and lower it before the next access. A tick and a bus load can still meet in one cycle, because the prescaler runs freely while the bus is active. The bench deliberately writes while the counter is ticking every cycle, so that collision is exercised.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int OFF_W = 3;

  typedef enum logic [OFF_W-1:0] {
    REG_MODE  = 3'd0,
    REG_PRE_L = 3'd1,
    REG_PRE_H = 3'd2,
    REG_RLD_L = 3'd3,
    REG_RLD_H = 3'd4,
    REG_CUR_L = 3'd5,
    REG_CUR_H = 3'd6
  } reg_off_e;

  localparam int B_RUN     = 0;
  localparam int B_REPEAT  = 1;
  localparam int B_DOWN    = 2;
  localparam int B_RESTART = 3;
endpackage

// File: rtl/tmr_pair_reg.sv
// Split-byte register: low byte waits in a holding latch, high write commits.
module tmr_pair_reg #(
  parameter int BYTE_W = 8,
  parameter bit KEEP   = 1'b1,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic              commit,
  output logic [WORD_W-1:0] commit_val,
  output logic [WORD_W-1:0] held
);
  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst)        lo_q <= '0;
    else if (lo_we) lo_q <= wdata;
  end

  assign commit     = hi_we;
  assign commit_val = {wdata, lo_q};

  generate
    if (KEEP) begin : g_keep
      logic [WORD_W-1:0] val_q;
      always_ff @(posedge clk) begin
        if (rst)        val_q <= '0;
        else if (hi_we) val_q <= commit_val;
      end
      assign held = val_q;

      // R9
      commit_chk: assert property (@(posedge clk) disable iff (rst)
        hi_we |=> val_q[BYTE_W-1:0] == $past(lo_q));
    end else begin : g_pass
      assign held = '0;
    end
  endgenerate
endmodule

// File: rtl/tmr_prescaler.sv
// Tick generator: one tick every (div + 1) cycles while running.
module tmr_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         div_commit,
  input  logic [W-1:0] div,
  output logic         tick
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst)                              cnt_q <= '0;
    else if (div_commit || !run || tick)  cnt_q <= '0;
    else                                  cnt_q <= cnt_q + ONE;
  end

  // R3
  tick_restart_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> cnt_q == '0);
  // R3
  div_restart_chk: assert property (@(posedge clk) disable iff (rst)
    div_commit |=> cnt_q == '0);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/tmr_accum.sv
// Count register, mode bits and zero-crossing handling.
module tmr_accum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_we,
  input  logic [3:0]   mode_wd,
  input  logic         cnt_commit,
  input  logic [W-1:0] cnt_val,
  input  logic [W-1:0] reload,
  input  logic         tick,
  output logic [W-1:0] acc,
  output logic         run,
  output logic         repeat_on,
  output logic         down,
  output logic         zero_evt
);
  import tmr_pkg::*;

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] acc_q;
  logic         run_q, repeat_q, down_q, zero_q;
  logic [W-1:0] step_v;
  logic         restart, bus_load, zero_hit;

  assign step_v   = down_q ? (acc_q - ONE) : (acc_q + ONE);
  assign restart  = mode_we && mode_wd[B_RESTART];
  assign bus_load = cnt_commit || restart;
  assign zero_hit = tick && !bus_load && (step_v == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      run_q    <= 1'b0;
      repeat_q <= 1'b0;
      down_q   <= 1'b0;
      zero_q   <= 1'b0;
    end else begin
      zero_q <= zero_hit;

      if (cnt_commit)    acc_q <= cnt_val;
      else if (restart)  acc_q <= reload;
      else if (tick) begin
        if (step_v == '0) acc_q <= repeat_q ? reload : '0;
        else              acc_q <= step_v;
      end

      if (mode_we) begin
        run_q    <= mode_wd[B_RUN];
        repeat_q <= mode_wd[B_REPEAT];
        down_q   <= mode_wd[B_DOWN];
      end else if (zero_hit && !repeat_q) begin
        run_q <= 1'b0;
      end
    end
  end

  assign acc       = acc_q;
  assign run       = run_q;
  assign repeat_on = repeat_q;
  assign down      = down_q;
  assign zero_evt  = zero_q;

  // R7
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (zero_hit && !repeat_q && !mode_we) |=> (!run_q && acc_q == '0));
  // R6
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (zero_hit && repeat_q) |=> (acc_q == $past(reload) && zero_q));
  // R8
  bus_wins_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_commit |=> (acc_q == $past(cnt_val) && !zero_q));
  // R4
  up_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !bus_load && !zero_hit && !down_q) |=> acc_q == $past(acc_q) + ONE);
  // R5
  down_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !bus_load && !zero_hit && down_q) |=> acc_q == $past(acc_q) - ONE);
endmodule

// File: rtl/tmr_readout.sv
// Registered read path with count snapshot.
module tmr_readout #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd,
  input  logic [tmr_pkg::OFF_W-1:0] off,
  input  logic                      run,
  input  logic                      repeat_on,
  input  logic                      down,
  input  logic [WORD_W-1:0]         acc,
  output logic [BYTE_W-1:0]         rdata
);
  import tmr_pkg::*;

  logic [WORD_W-1:0] snap_q;
  logic [BYTE_W-1:0] rdata_q;
  logic [BYTE_W-1:0] mode_rd;

  always_comb begin
    mode_rd           = '0;
    mode_rd[B_RUN]    = run;
    mode_rd[B_REPEAT] = repeat_on;
    mode_rd[B_DOWN]   = down;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q  <= '0;
      rdata_q <= '0;
    end else begin
      rdata_q <= '0;
      if (rd) begin
        case (off)
          REG_MODE:  rdata_q <= mode_rd;
          REG_CUR_L: begin
            rdata_q <= acc[BYTE_W-1:0];
            snap_q  <= acc;
          end
          REG_CUR_H: rdata_q <= snap_q[WORD_W-1:BYTE_W];
          default:   rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata = rdata_q;

  // R2
  mode_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && off == REG_MODE) |=> rdata_q[BYTE_W-1:B_RESTART] == '0);
  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> rdata_q == '0);
  // R10
  snap_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && off == REG_CUR_L) |=> snap_q == $past(acc));
endmodule

// File: rtl/tick_timer_top.sv
module tick_timer_top #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [tmr_pkg::OFF_W-1:0] bus_off,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [BYTE_W-1:0]         bus_wdata,
  output logic [BYTE_W-1:0]         rd_data,
  output logic                      zero_evt
);
  import tmr_pkg::*;

  localparam int NPAIR = 3;
  localparam logic [OFF_W-1:0] LO_OFF [NPAIR] = '{REG_PRE_L, REG_RLD_L, REG_CUR_L};

  logic [NPAIR-1:0]  p_commit;
  logic [WORD_W-1:0] p_val  [NPAIR];
  logic [WORD_W-1:0] p_held [NPAIR];

  generate
    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
      tmr_pair_reg #(.BYTE_W(BYTE_W), .KEEP(i != 2)) u_pair (
        .clk        (clk),
        .rst        (rst),
        .lo_we      (bus_wr && bus_off == LO_OFF[i]),
        .hi_we      (bus_wr && bus_off == LO_OFF[i] + 3'd1),
        .wdata      (bus_wdata),
        .commit     (p_commit[i]),
        .commit_val (p_val[i]),
        .held       (p_held[i])
      );
    end
  endgenerate

  logic              tick, run, repeat_on, down;
  logic [WORD_W-1:0] acc;
  logic              mode_we;

  assign mode_we = bus_wr && bus_off == REG_MODE;

  tmr_prescaler #(.W(WORD_W)) u_pre (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .div_commit (p_commit[0]),
    .div        (p_held[0]),
    .tick       (tick)
  );

  tmr_accum #(.W(WORD_W)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .mode_we    (mode_we),
    .mode_wd    (bus_wdata[3:0]),
    .cnt_commit (p_commit[2]),
    .cnt_val    (p_val[2]),
    .reload     (p_held[1]),
    .tick       (tick),
    .acc        (acc),
    .run        (run),
    .repeat_on  (repeat_on),
    .down       (down),
    .zero_evt   (zero_evt)
  );

  tmr_readout #(.BYTE_W(BYTE_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd        (bus_rd),
    .off       (bus_off),
    .run       (run),
    .repeat_on (repeat_on),
    .down      (down),
    .acc       (acc),
    .rdata     (rd_data)
  );
endmodule

// File: tb/tb_tick_timer_top.sv
module tb_tick_timer_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] bus_off;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata;
  logic [7:0] rd_data;
  logic       zero_evt;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  int cyc    = 0;

  tick_timer_top dut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference, updated on each rising edge.
  int m_en, m_auto, m_dn, m_div, m_rel, m_acc, m_pc, m_dlo, m_rlo, m_clo, m_snap, m_rd;
  bit m_z;
  bit m_live = 1'b0;

  always @(posedge clk) begin : model
    int stp;
    bit tk, ld, rs, cw;
    if (rst) begin
      m_en = 0; m_auto = 0; m_dn = 0; m_div = 0; m_rel = 0; m_acc = 0; m_pc = 0;
      m_dlo = 0; m_rlo = 0; m_clo = 0; m_snap = 0; m_rd = 0; m_z = 0;
    end else begin
      tk  = (m_en != 0) && (m_pc == m_div);
      stp = (m_dn != 0) ? (m_acc + 65535) % 65536 : (m_acc + 1) % 65536;
      cw  = bus_wr && bus_off == 3'd6;
      rs  = bus_wr && bus_off == 3'd0 && bus_wdata[3];
      ld  = cw || rs;
      m_rd = 0;
      if (bus_rd) begin
        case (bus_off)
          3'd0: m_rd = m_en + 2 * m_auto + 4 * m_dn;
          3'd5: begin m_rd = m_acc % 256; m_snap = m_acc; end
          3'd6: m_rd = m_snap / 256;
          default: m_rd = 0;
        endcase
      end
      m_z = tk && !ld && stp == 0;
      if ((bus_wr && bus_off == 3'd2) || m_en == 0 || tk) m_pc = 0;
      else m_pc = m_pc + 1;
      if (cw)      m_acc = bus_wdata * 256 + m_clo;
      else if (rs) m_acc = m_rel;
      else if (tk) m_acc = (stp == 0) ? ((m_auto != 0) ? m_rel : 0) : stp;
      if (bus_wr && bus_off == 3'd0) begin
        m_en = bus_wdata[0]; m_auto = bus_wdata[1]; m_dn = bus_wdata[2];
      end else if (m_z && m_auto == 0) begin
        m_en = 0;
      end
      if (bus_wr) begin
        case (bus_off)
          3'd1: m_dlo = bus_wdata;
          3'd2: m_div = bus_wdata * 256 + m_dlo;
          3'd3: m_rlo = bus_wdata;
          3'd4: m_rel = bus_wdata * 256 + m_rlo;
          3'd5: m_clo = bus_wdata;
          default: ;
        endcase
      end
    end
    m_live = 1'b1;
  end

  // Per-cycle comparison, away from the active edge; zero-pulse bookkeeping.
  int zcount = 0, zlast = 0, zprev = 0;
  always @(negedge clk) begin
    if (m_live && !rst && !done) begin
      chk(rd_data == 8'(m_rd), "R11 model rd_data", rd_data, m_rd);
      chk(zero_evt == m_z, "R6 model zero_evt", zero_evt, m_z);
    end
    if (zero_evt) begin
      zcount++;
      zprev = zlast;
      zlast = cyc;
    end
  end

  // Tasks are entered at a falling edge and return at one.
  task automatic wr(input logic [2:0] off, input logic [7:0] d);
    bus_wr = 1'b1; bus_off = off; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic rd_chk(input logic [2:0] off, input logic [7:0] exp, input string req);
    bus_rd = 1'b1; bus_off = off;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic wait_pulses(input int n);
    int target;
    target = zcount + n;
    for (int i = 0; i < 2000 && zcount < target; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin : stim
    int z0;
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_off = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(zero_evt == 1'b0, "R1 zero_evt", zero_evt, 0);
    rd_chk(3'd0, 8'h00, "R1 mode");
    rd_chk(3'd5, 8'h00, "R1 count low");
    rd_chk(3'd6, 8'h00, "R1 count high");

    // R2 layout: 0xFE keeps only REPEAT and DOWN
    wr(3'd0, 8'hFE);
    rd_chk(3'd0, 8'h06, "R2 mode readback");
    wr(3'd0, 8'h00);

    // R9 paired writes and stale latch
    wr(3'd5, 8'h34); wr(3'd6, 8'h12);
    rd_chk(3'd5, 8'h34, "R9 low");
    rd_chk(3'd6, 8'h12, "R9 high");
    wr(3'd6, 8'h56);
    rd_chk(3'd5, 8'h34, "R9 stale low");
    rd_chk(3'd6, 8'h56, "R9 stale high");

    // R11 write-only and unused offsets, idle cycle
    rd_chk(3'd1, 8'h00, "R11 offset1");
    rd_chk(3'd7, 8'h00, "R11 offset7");
    @(negedge clk);
    chk(rd_data == 8'h00, "R11 idle", rd_data, 0);

    // R3 divisor 3, reload 0xFFFE, up, repeat: pulse every 8 cycles
    wr(3'd1, 8'h03); wr(3'd2, 8'h00);
    wr(3'd3, 8'hFE); wr(3'd4, 8'hFF);
    wr(3'd0, 8'h0B);
    wait_pulses(3);
    chk(zlast - zprev == 8, "R3 period div=3", zlast - zprev, 8);
    // R3 divisor 0: pulse every 2 cycles
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    wait_pulses(3);
    chk(zlast - zprev == 2, "R3 period div=0", zlast - zprev, 2);
    wr(3'd0, 8'h00);

    // R4 up wrap, one-shot stop (R7)
    wr(3'd5, 8'hFD); wr(3'd6, 8'hFF);
    z0 = zcount;
    wr(3'd0, 8'h01);
    repeat (10) @(negedge clk);
    chk(zcount - z0 == 1, "R4 single crossing", zcount - z0, 1);
    rd_chk(3'd0, 8'h00, "R7 RUN cleared up");
    rd_chk(3'd5, 8'h00, "R4 count low at zero");
    rd_chk(3'd6, 8'h00, "R4 count high at zero");

    // R5 down to zero, one-shot
    wr(3'd5, 8'h05); wr(3'd6, 8'h00);
    z0 = zcount;
    wr(3'd0, 8'h05);
    repeat (12) @(negedge clk);
    chk(zcount - z0 == 1, "R5 single crossing", zcount - z0, 1);
    rd_chk(3'd0, 8'h04, "R7 RUN cleared down");
    rd_chk(3'd5, 8'h00, "R5 count at zero");

    // R6 periodic down from reload 3: pulse every 3 cycles
    wr(3'd3, 8'h03); wr(3'd4, 8'h00);
    wr(3'd0, 8'h0F);
    wait_pulses(3);
    chk(zlast - zprev == 3, "R6 periodic interval", zlast - zprev, 3);
    rd_chk(3'd0, 8'h07, "R6 RUN kept");
    wr(3'd0, 8'h00);

    // R8 RESTART while ticking every cycle
    wr(3'd3, 8'h00); wr(3'd4, 8'h01);
    wr(3'd5, 8'h00); wr(3'd6, 8'h20);
    wr(3'd0, 8'h01);
    repeat (5) @(negedge clk);
    wr(3'd0, 8'h09);
    rd_chk(3'd5, 8'h00, "R8 restart low");
    wr(3'd0, 8'h00);
    rd_chk(3'd6, 8'h01, "R8 restart high");
    // R8 count commit collides with a tick
    wr(3'd0, 8'h01);
    wr(3'd5, 8'h10); wr(3'd6, 8'h00);
    wr(3'd0, 8'h00);
    rd_chk(3'd5, 8'h11, "R8 commit beats tick");

    // R10 snapshot while counting up across a byte boundary
    wr(3'd5, 8'hFC); wr(3'd6, 8'h01);
    wr(3'd0, 8'h01);
    rd_chk(3'd5, 8'hFC, "R10 live low");
    repeat (10) @(negedge clk);
    rd_chk(3'd6, 8'h01, "R10 snapshot high");
    wr(3'd0, 8'h00);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule